// File: doc/BRIEF.md
# DSP Parallel Extension Decoder and Executor

This block takes the low byte of a 16-bit DSP instruction word, which encodes a small operation that runs in parallel with the main opcode, and decodes it into one of several classes. The four simple classes are carried out here: address-register modify, register-to-register move, single store to data memory and single load from data memory. Bits 7:4 of the byte pick the class. Each class lays out its operand fields in its own way. Where an address register is used to reach memory, a single bit chooses whether it is then stepped by one or moved by its paired signed index register.

The block has no register storage of its own. It drives read selects into an external 32-entry by 16-bit register file and gets the values back combinationally. It has two write ports into that file: one for address-register updates and one for data results. It also drives a data-memory port whose reads return one cycle later. The two remaining classes (load/store pair and dual load) are only recognised. For those, the block raises a hand-off strobe and reports the class code so that an outside sequencer can carry them out. A load keeps the block busy for one cycle while the read data comes back. A word presented in that cycle is not accepted.

Top module: `xop_exec`

## Requirements
- R1: A word accepted with bits 7:0 equal to zero causes no register or memory write, reports class code 0 and raises `done` in the same cycle.
- R2: For an accepted word with a non-zero low byte, `ext_class` shows the class chosen by bits 7:4 in the cycle of acceptance. The codes are: 0→1 (address modify), 1→2 (move), 2–3→3 (store), 4–7→4 (load), 8–B→5 (pair), C–F→6 (dual). When no word is accepted, `ext_class` is 0.
- R3: Address modify names address register bits 1:0 (register numbers 0–3). Bits 3:2 select the action on it: 0 clears it, 1 subtracts one, 2 adds one, 3 adds index register (4 + bits 1:0).
- R4: Move copies register 28 + bits 1:0 into register 24 + bits 3:2.
- R5: Store writes register 28 + bits 4:3 to the data-memory address held in address register bits 1:0.
- R6: Load reads data memory at the address held in address register bits 1:0. One cycle after acceptance, it writes the returned word into register 24 + bits 5:3 and raises `done` in that same cycle.
- R7: For store and load, bit 2 set adds the paired index register (as a signed value) to the address register used, and bit 2 clear adds one. All address arithmetic wraps modulo 2^16.
- R8: The memory access of a store or load uses the address register's value from before its post-modify.
- R9: Pair and dual words raise `handoff` for one cycle, keep `done` low and cause no register or memory write.
- R10: While `busy` is high (the cycle after a load is accepted), a word on `ext_valid` is ignored: it makes no memory access, no address-register write and no class report.
- R11: After reset, `busy`, `done` and `handoff` are low.
- R12: Address modify, move and store raise `done` in their acceptance cycle, with their register and memory writes presented in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_valid | input | 1 | Instruction word is present |
| ext_word | input | 16 | Instruction word; bits 7:0 are decoded |
| ar_rsel | output | 5 | Register-file read select for the address register |
| ar_rdata | input | 16 | Address register value |
| ix_rsel | output | 5 | Read select for the paired index register |
| ix_rdata | input | 16 | Index register value |
| src_rsel | output | 5 | Read select for the source register of a move or store |
| src_rdata | input | 16 | Source register value |
| ar_we | output | 1 | Address-register write enable |
| ar_wsel | output | 5 | Address-register write select |
| ar_wdata | output | 16 | New address-register value |
| dw_we | output | 1 | Data-result write enable |
| dw_sel | output | 5 | Data-result write select |
| dw_data | output | 16 | Data-result value |
| mem_addr | output | 16 | Data-memory address |
| mem_we | output | 1 | Data-memory write strobe |
| mem_wdata | output | 16 | Data-memory write value |
| mem_re | output | 1 | Data-memory read strobe |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| busy | output | 1 | Load result pending; new words are ignored |
| done | output | 1 | Operation completed this cycle |
| handoff | output | 1 | Pair or dual word recognised for the outside sequencer |
| ext_class | output | 3 | Decoded class code of the accepted word |

## Verification
The assertions check on every cycle the properties that hold for any word. A load is always followed by its write-back and `done`. Nothing leaves the block while it is busy, and a hand-off never writes anything. Memory is never read and written together, address writes only target registers 0–3, and a zero extension byte does nothing. The specific arithmetic can only be shown by the bench's sweep over all 256 extension bytes, run twice with different register and memory contents (forward and negative index values, and an address at 0xFFFF for wrap-around). That arithmetic covers the cleared, stepped or index-moved address values, the moved and loaded data, the stored word and which address it reached. A dedicated scenario shows that a word offered during the load's busy cycle leaves registers and memory untouched.

// File: rtl/xop_pkg.sv
package xop_pkg;

    localparam int REG_AW   = 5;
    localparam int AR_BASE  = 0;
    localparam int IX_BASE  = 4;
    localparam int DST_BASE = 24;
    localparam int SRC_BASE = 28;

    typedef enum logic [2:0] {
        XC_NONE  = 3'd0,
        XC_ARMOD = 3'd1,
        XC_MOVE  = 3'd2,
        XC_STORE = 3'd3,
        XC_LOAD  = 3'd4,
        XC_PAIR  = 3'd5,
        XC_DUAL  = 3'd6
    } xclass_e;

    typedef enum logic [2:0] {
        PM_HOLD  = 3'd0,
        PM_CLEAR = 3'd1,
        PM_DEC   = 3'd2,
        PM_INC   = 3'd3,
        PM_ADDIX = 3'd4
    } pmod_e;

    typedef struct packed {
        xclass_e             cls;
        logic [1:0]          ar;
        pmod_e               pm;
        logic [REG_AW-1:0]   src;
        logic [REG_AW-1:0]   dst;
        logic                mem_wr;
        logic                mem_rd;
        logic                rf_wr;
        logic                handoff;
    } xdec_t;

    function automatic logic [REG_AW-1:0] reg_num(input int base, input logic [2:0] off);
        return REG_AW'(base) + REG_AW'(off);
    endfunction

    function automatic pmod_e step_mode(input logic use_index);
        return use_index ? PM_ADDIX : PM_INC;
    endfunction

    function automatic logic single_cycle(input xclass_e c);
        return (c == XC_NONE) || (c == XC_ARMOD) || (c == XC_MOVE) || (c == XC_STORE);
    endfunction

endpackage

// File: rtl/xop_decode.sv
module xop_decode
    import xop_pkg::*;
(
    input  logic [7:0] xbyte,
    output xdec_t      dec
);

    always_comb begin
        dec         = '0;
        dec.cls     = XC_NONE;
        dec.pm      = PM_HOLD;
        dec.ar      = xbyte[1:0];
        if (xbyte != 8'h00) begin
            case (xbyte[7:4])
                4'h0: begin
                    dec.cls = XC_ARMOD;
                    case (xbyte[3:2])
                        2'd0:    dec.pm = PM_CLEAR;
                        2'd1:    dec.pm = PM_DEC;
                        2'd2:    dec.pm = PM_INC;
                        default: dec.pm = PM_ADDIX;
                    endcase
                end
                4'h1: begin
                    dec.cls   = XC_MOVE;
                    dec.src   = reg_num(SRC_BASE, {1'b0, xbyte[1:0]});
                    dec.dst   = reg_num(DST_BASE, {1'b0, xbyte[3:2]});
                    dec.rf_wr = 1'b1;
                end
                4'h2, 4'h3: begin
                    dec.cls    = XC_STORE;
                    dec.src    = reg_num(SRC_BASE, {1'b0, xbyte[4:3]});
                    dec.mem_wr = 1'b1;
                    dec.pm     = step_mode(xbyte[2]);
                end
                4'h4, 4'h5, 4'h6, 4'h7: begin
                    dec.cls    = XC_LOAD;
                    dec.dst    = reg_num(DST_BASE, xbyte[5:3]);
                    dec.mem_rd = 1'b1;
                    dec.pm     = step_mode(xbyte[2]);
                end
                4'h8, 4'h9, 4'hA, 4'hB: begin
                    dec.cls     = XC_PAIR;
                    dec.handoff = 1'b1;
                end
                default: begin
                    dec.cls     = XC_DUAL;
                    dec.handoff = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/xop_postmod.sv
module xop_postmod
    import xop_pkg::*;
#(
    parameter int DW = 16
) (
    input  pmod_e          pm,
    input  logic [DW-1:0]  cur,
    input  logic [DW-1:0]  ix,
    output logic [DW-1:0]  nxt,
    output logic           wr
);

    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        case (pm)
            PM_CLEAR: nxt = '0;
            PM_DEC:   nxt = cur - ONE;
            PM_INC:   nxt = cur + ONE;
            PM_ADDIX: nxt = cur + ix;
            default:  nxt = cur;
        endcase
        wr = (pm != PM_HOLD);
    end

endmodule

// File: rtl/xop_exec.sv
module xop_exec
    import xop_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_valid,
    input  logic [15:0]       ext_word,
    output logic [REG_AW-1:0] ar_rsel,
    input  logic [DW-1:0]     ar_rdata,
    output logic [REG_AW-1:0] ix_rsel,
    input  logic [DW-1:0]     ix_rdata,
    output logic [REG_AW-1:0] src_rsel,
    input  logic [DW-1:0]     src_rdata,
    output logic              ar_we,
    output logic [REG_AW-1:0] ar_wsel,
    output logic [DW-1:0]     ar_wdata,
    output logic              dw_we,
    output logic [REG_AW-1:0] dw_sel,
    output logic [DW-1:0]     dw_data,
    output logic [DW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_re,
    input  logic [DW-1:0]     mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              handoff,
    output logic [2:0]        ext_class
);

    xdec_t             dec;
    logic              accept;
    logic              pm_wr;
    logic [DW-1:0]     pm_val;
    logic              ld_pend;
    logic [REG_AW-1:0] ld_dst;

    xop_decode u_dec (
        .xbyte (ext_word[7:0]),
        .dec   (dec)
    );

    xop_postmod #(.DW(DW)) u_pm (
        .pm  (dec.pm),
        .cur (ar_rdata),
        .ix  (ix_rdata),
        .nxt (pm_val),
        .wr  (pm_wr)
    );

    assign accept   = ext_valid && !ld_pend && !rst;
    assign busy     = ld_pend;

    assign ar_rsel  = reg_num(AR_BASE, {1'b0, dec.ar});
    assign ix_rsel  = reg_num(IX_BASE, {1'b0, dec.ar});
    assign src_rsel = dec.src;

    assign ar_we    = accept && pm_wr;
    assign ar_wsel  = ar_rsel;
    assign ar_wdata = pm_val;

    assign mem_addr  = ar_rdata;
    assign mem_wdata = src_rdata;
    assign mem_we    = accept && dec.mem_wr;
    assign mem_re    = accept && dec.mem_rd;

    assign dw_we   = ld_pend || (accept && dec.rf_wr);
    assign dw_sel  = ld_pend ? ld_dst : dec.dst;
    assign dw_data = ld_pend ? mem_rdata : src_rdata;

    assign done      = ld_pend || (accept && single_cycle(dec.cls));
    assign handoff   = accept && dec.handoff;
    assign ext_class = accept ? dec.cls : XC_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_pend <= 1'b0;
            ld_dst  <= '0;
        end else begin
            ld_pend <= mem_re;
            if (mem_re) ld_dst <= dec.dst;
        end
    end

    // R6
    load_writeback_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mem_re) |-> (dw_we && done && busy));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!mem_we && !mem_re && !ar_we && !handoff && ext_class == 3'd0));

    // R9
    handoff_clean_chk: assert property (@(posedge clk) disable iff (rst)
        handoff |-> (!done && !dw_we && !ar_we && !mem_we && !mem_re));

    // R5
    mem_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R3
    ar_target_chk: assert property (@(posedge clk) disable iff (rst)
        ar_we |-> (ar_wsel < 5'd4));

    // R1
    zero_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && !busy && ext_word[7:0] == 8'h00)
            |-> (done && ext_class == 3'd0 && !ar_we && !dw_we && !mem_we && !mem_re));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !busy);

endmodule

// File: tb/tb_xop_exec.sv
module tb_xop_exec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic [4:0]  ar_rsel, ix_rsel, src_rsel, ar_wsel, dw_sel;
    logic [15:0] ar_rdata, ix_rdata, src_rdata, ar_wdata, dw_data;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        ar_we, dw_we, mem_we, mem_re, busy, done, handoff;
    logic [2:0]  ext_class;

    logic [15:0] rf     [32];
    logic [15:0] mem    [256];
    logic [15:0] pat_rf [32];
    logic [15:0] pat_mem[256];
    logic [15:0] exp_rf [32];
    logic [15:0] exp_mem[256];
    logic        preload = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    xop_exec dut (
        .clk(clk), .rst(rst), .ext_valid(ext_valid), .ext_word(ext_word),
        .ar_rsel(ar_rsel), .ar_rdata(ar_rdata), .ix_rsel(ix_rsel), .ix_rdata(ix_rdata),
        .src_rsel(src_rsel), .src_rdata(src_rdata),
        .ar_we(ar_we), .ar_wsel(ar_wsel), .ar_wdata(ar_wdata),
        .dw_we(dw_we), .dw_sel(dw_sel), .dw_data(dw_data),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .handoff(handoff), .ext_class(ext_class)
    );

    assign ar_rdata  = rf[ar_rsel];
    assign ix_rdata  = rf[ix_rsel];
    assign src_rdata = rf[src_rsel];

    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < 32; i++)  rf[i]  <= pat_rf[i];
            for (int j = 0; j < 256; j++) mem[j] <= pat_mem[j];
        end else begin
            if (ar_we)  rf[ar_wsel] <= ar_wdata;
            if (dw_we)  rf[dw_sel]  <= dw_data;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_class(input logic [7:0] lo);
        if (lo == 8'h00) return 3'd0;
        case (lo[7:4])
            4'h0: return 3'd1;
            4'h1: return 3'd2;
            4'h2, 4'h3: return 3'd3;
            4'h4, 4'h5, 4'h6, 4'h7: return 3'd4;
            4'h8, 4'h9, 4'hA, 4'hB: return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

    // arithmetic model of R3..R8
    task automatic model(input logic [15:0] w);
        logic [7:0]  lo = w[7:0];
        int          a  = int'(lo[1:0]);
        logic [15:0] v;
        if (lo == 8'h00) return;
        case (exp_class(lo))
            3'd1: case (lo[3:2])
                2'd0: exp_rf[a] = 16'h0000;
                2'd1: exp_rf[a] = exp_rf[a] - 16'd1;
                2'd2: exp_rf[a] = exp_rf[a] + 16'd1;
                default: exp_rf[a] = exp_rf[a] + exp_rf[4 + a];
            endcase
            3'd2: exp_rf[24 + int'(lo[3:2])] = exp_rf[28 + int'(lo[1:0])];
            3'd3: begin
                exp_mem[exp_rf[a][7:0]] = exp_rf[28 + int'(lo[4:3])];
                exp_rf[a] = exp_rf[a] + (lo[2] ? exp_rf[4 + a] : 16'd1);
            end
            3'd4: begin
                v = exp_mem[exp_rf[a][7:0]];
                exp_rf[a] = exp_rf[a] + (lo[2] ? exp_rf[4 + a] : 16'd1);
                exp_rf[24 + int'(lo[5:3])] = v;
            end
            default: ;
        endcase
    endtask

    task automatic setup(input logic [15:0] w, input int var_sel);
        for (int i = 0; i < 32; i++) begin
            if (i < 4)
                pat_rf[i] = (var_sel == 0) ? 16'h0010 + 16'(i) * 16'h0021 + {8'h00, w[7:0]}
                          : ((i == int'(w[1:0])) ? 16'hFFFF : 16'h00F0 + 16'(i));
            else if (i < 8)
                pat_rf[i] = (var_sel == 0) ? 16'h0003 + 16'(i) : 16'hFFFE - 16'(i);
            else
                pat_rf[i] = 16'hA000 + 16'(i) * 16'h0111 + w;
            exp_rf[i] = pat_rf[i];
        end
        for (int j = 0; j < 256; j++) begin
            pat_mem[j] = {8'(j) ^ 8'h3C, 8'(j)} + 16'(var_sel);
            exp_mem[j] = pat_mem[j];
        end
        @(negedge clk);
        preload = 1'b1;
        @(negedge clk);
        preload = 1'b0;
    endtask

    task automatic compare_state(input string req);
        int bad = -1;
        for (int i = 0; i < 32; i++) if (bad < 0 && rf[i] !== exp_rf[i]) bad = i;
        chk(bad < 0, {req, " registers"}, (bad < 0) ? 32'h0 : {bad[15:0], rf[bad]},
            (bad < 0) ? 32'h0 : {bad[15:0], exp_rf[bad]});
        bad = -1;
        for (int j = 0; j < 256; j++) if (bad < 0 && mem[j] !== exp_mem[j]) bad = j;
        chk(bad < 0, {req, " memory"}, (bad < 0) ? 32'h0 : {bad[15:0], mem[bad]},
            (bad < 0) ? 32'h0 : {bad[15:0], exp_mem[bad]});
    endtask

    task automatic run_op(input logic [15:0] w, input int var_sel);
        logic [2:0] c = exp_class(w[7:0]);
        string      tag;
        case (c)
            3'd0: tag = "R1";
            3'd1: tag = "R3";
            3'd2: tag = "R4";
            3'd3: tag = "R5/R7/R8";
            3'd4: tag = "R6/R7/R8";
            default: tag = "R9";
        endcase
        setup(w, var_sel);
        ext_word  = w;
        ext_valid = 1'b1;
        #1;
        chk(ext_class == c, "R2 class code", 32'(ext_class), 32'(c));
        // R12 single-cycle done, R6 load done deferred, R9 no done
        chk(done == (c <= 3'd3), "R12 done in acceptance cycle", 32'(done), 32'(c <= 3'd3));
        chk(handoff == (c >= 3'd5), "R9 handoff strobe", 32'(handoff), 32'(c >= 3'd5));
        model(w);
        @(negedge clk);
        ext_valid = 1'b0;
        if (c == 3'd4) begin
            #1;
            chk(done && busy, "R6 done one cycle after load", 32'({done, busy}), 32'h3);
            @(negedge clk);
        end
        compare_state(tag);
    endtask

    initial begin
        #(10 * 150000);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++)  pat_rf[i]  = '0;
        for (int j = 0; j < 256; j++) pat_mem[j] = '0;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk(!busy && !done && !handoff, "R11 idle after reset", 32'({busy, done, handoff}), 32'h0);

        for (int v = 0; v < 2; v++)
            for (int b = 0; b < 256; b++)
                run_op({8'(b * 7 + v), 8'(b)}, v);

        // R10: a store offered while the load result is pending must be ignored
        setup(16'h0048, 0);
        ext_word  = 16'h0048;
        ext_valid = 1'b1;
        model(16'h0048);
        @(negedge clk);
        ext_word  = 16'h0021;
        #1;
        chk(ext_class == 3'd0 && !mem_we && !ar_we, "R10 word ignored while busy",
            32'({ext_class, mem_we, ar_we}), 32'h0);
        chk(done && busy, "R10 load completes while busy", 32'({done, busy}), 32'h3);
        @(negedge clk);
        ext_valid = 1'b0;
        compare_state("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule